// File: doc/BRIEF.md
# Slot Address Decoder with Byte-Lane Adapter

This block sits between a host-side local bus and a row of plug-in module slots. Each host request names one of four windows:

- a 16-bit control window;
- a 1 KiB register window, split per slot into I/O, ID and interrupt spaces;
- a halfword memory window;
- a byte memory window.

The block turns the address into a slot number, a space selector and an offset. It raises one registered strobe for the chosen slot and space in the cycle after the request, and presents offset, size, direction and write data alongside.

A small byte-wide configuration port holds one big-endian mode bit for each of the first three windows. When the mode bit of a window is set:

- a byte access has address bit 0 inverted before decode;
- a halfword access has its two data bytes exchanged, both on write data and on returned read data.

The byte memory window never adapts.

The block drops a request that targets an empty slot or uses a size the window does not accept. Such a request raises no strobe, and a read of it returns zero. Every read gets a response one cycle after the request, flagged by a valid bit.

Top module: `slot_decoder`

## Requirements
- R1: In the register window (req_win=1) the slot is the address shifted right by 8 and the space is address bits 7:6. Space 2 raises id_stb with offset addr&0x3F. Space 3 raises int_stb with offset addr&0x3F. Spaces 0 and 1 raise io_stb with offset addr&0x7F. Strobes are one-hot per slot (bit i = slot i) and last exactly one cycle, the cycle after the request.
- R2: In the halfword memory window (req_win=2) the slot is address bits 24:23, the offset is address bits 22:0, and mem_stb is raised.
- R3: In the byte memory window (req_win=3) the slot is the address shifted right by 22, the offset is address bits 21:0, and bmem_stb is raised. The endian mode bits never alter its address or data.
- R4: The endian mode bit of window w (w=0,1,2) is bit 0 of configuration byte 0x2B+4*w. It is written through cfg_we, and cfg_rdata returns it in bit 0 with the other bits zero. Other configuration addresses read zero and ignore writes. All mode bits clear at reset.
- R5: With the mode bit of window 1 or 2 set, a byte access (req_size=0) inverts address bit 0 before decode.
- R6: With the mode bit of window 0, 1 or 2 set, a halfword access (req_size=1) exchanges the two bytes of the write data on dev_wdata and of the returned read data.
- R7: Accepted sizes are halfword only for the control window, byte or halfword for the register and halfword memory windows, and byte only for the byte memory window. Any other size raises no strobe, and a read of it returns zero.
- R8: A request to a slot whose slot_present bit is low, or whose decoded slot number is not below NSLOT, raises no strobe, and a read of it returns zero.
- R9: rsp_valid is high for exactly the cycle after each read request and never after a write. rsp_rdata carries the selected slot's 16-bit slot_rdata lane (or ctl_rdata), adapted per R6.
- R10: In the control window (req_win=0) an accepted request raises ctl_stb with offset equal to address bits 7:0, and a read returns ctl_rdata.
- R11: After reset all strobes and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_win | input | 2 | Window: 0 control, 1 register, 2 halfword memory, 3 byte memory |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 1 | 0 byte, 1 halfword |
| req_addr | input | ADDR_W | Window-relative address |
| req_wdata | input | 16 | Write data |
| slot_present | input | NSLOT | One bit per populated slot |
| slot_rdata | input | 16*NSLOT | Read data, one 16-bit lane per slot |
| ctl_rdata | input | 16 | Control window read data |
| cfg_we | input | 1 | Configuration byte write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| io_stb | output | NSLOT | I/O space strobe per slot |
| id_stb | output | NSLOT | ID space strobe per slot |
| int_stb | output | NSLOT | Interrupt space strobe per slot |
| mem_stb | output | NSLOT | Halfword memory strobe per slot |
| bmem_stb | output | NSLOT | Byte memory strobe per slot |
| ctl_stb | output | 1 | Control window strobe |
| dev_write | output | 1 | Direction of the strobed access |
| dev_size | output | 1 | Size of the strobed access |
| dev_offset | output | 23 | Offset within the selected space |
| dev_wdata | output | 16 | Adapted write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |

## Verification
The bench uses the default parameters: four slots, a 25-bit address and slot fields at bits 8, 23 and 22. With these values the unused upper address bits of the register and byte memory windows can push the decoded slot number to four or more. This makes the out-of-range empty case reachable alongside slots cleared through slot_present. The bench also exercises the endian bits one window at a time, so that a swap leaking into the wrong window or into the byte memory window shows up at dev_offset, dev_wdata or rsp_rdata.

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int NSLOT         = 4,
  parameter int ADDR_W        = 25,
  parameter int REG_SLOT_LSB  = 8,
  parameter int HMEM_SLOT_LSB = 23,
  parameter int BMEM_SLOT_LSB = 22,
  parameter int IO_OFF_W      = 7,
  parameter int ID_OFF_W      = 6,
  parameter int NBE           = 3,
  parameter logic [7:0] CFG_BASE = 8'h2B,
  parameter int CFG_STEP      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_win,
  input  logic                  req_write,
  input  logic                  req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [15:0]           req_wdata,
  input  logic [NSLOT-1:0]      slot_present,
  input  logic [16*NSLOT-1:0]   slot_rdata,
  input  logic [15:0]           ctl_rdata,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_rdata,
  output logic [NSLOT-1:0]      io_stb,
  output logic [NSLOT-1:0]      id_stb,
  output logic [NSLOT-1:0]      int_stb,
  output logic [NSLOT-1:0]      mem_stb,
  output logic [NSLOT-1:0]      bmem_stb,
  output logic                  ctl_stb,
  output logic                  dev_write,
  output logic                  dev_size,
  output logic [HMEM_SLOT_LSB-1:0] dev_offset,
  output logic [15:0]           dev_wdata,
  output logic                  rsp_valid,
  output logic [15:0]           rsp_rdata
);
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int OFF_W = HMEM_SLOT_LSB;
  localparam logic [1:0] W_CTL = 2'd0, W_REG = 2'd1, W_HMEM = 2'd2, W_BMEM = 2'd3;

  logic [NBE-1:0] be_q;

  genvar w;
  generate
    for (w = 0; w < NBE; w++) begin : g_be
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) be_q[w] <= 1'b0;
        else if (cfg_we && cfg_addr == CFG_BASE + 8'(w * CFG_STEP)) be_q[w] <= cfg_wdata[0];
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NBE; i++)
      if (cfg_addr == CFG_BASE + 8'(i * CFG_STEP)) cfg_rdata[0] = be_q[i];
  end

  logic be_win, size_ok, swap, slot_ok, hit;
  logic [ADDR_W-1:0] a_adj, slot_full;
  logic [1:0] space;
  logic [OFF_W-1:0] off;
  logic [NSLOT-1:0] onehot;

  assign be_win  = (32'(req_win) < NBE) ? be_q[SW'(req_win)] : 1'b0;
  assign swap    = be_win && req_size;
  assign a_adj   = (be_win && !req_size) ? (req_addr ^ ADDR_W'(1)) : req_addr;
  assign space   = a_adj[REG_SLOT_LSB-1 -: 2];

  always_comb begin
    case (req_win)
      W_CTL:   size_ok = req_size;
      W_BMEM:  size_ok = !req_size;
      default: size_ok = 1'b1;
    endcase
    case (req_win)
      W_REG:   slot_full = a_adj >> REG_SLOT_LSB;
      W_HMEM:  slot_full = a_adj >> HMEM_SLOT_LSB;
      W_BMEM:  slot_full = a_adj >> BMEM_SLOT_LSB;
      default: slot_full = '0;
    endcase
    case (req_win)
      W_CTL:   off = OFF_W'(a_adj[REG_SLOT_LSB-1:0]);
      W_REG:   off = (space[1]) ? OFF_W'(a_adj[ID_OFF_W-1:0]) : OFF_W'(a_adj[IO_OFF_W-1:0]);
      W_HMEM:  off = OFF_W'(a_adj[HMEM_SLOT_LSB-1:0]);
      default: off = OFF_W'(a_adj[BMEM_SLOT_LSB-1:0]);
    endcase
  end

  assign slot_ok = (slot_full < ADDR_W'(NSLOT)) && slot_present[slot_full[SW-1:0]];
  assign hit     = req_valid && size_ok && (req_win == W_CTL || slot_ok);
  assign onehot  = (hit && req_win != W_CTL) ? (NSLOT'(1) << slot_full[SW-1:0]) : '0;

  logic rd_q, hit_q, ctl_q, swap_q;
  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_stb <= '0; id_stb <= '0; int_stb <= '0; mem_stb <= '0; bmem_stb <= '0;
      ctl_stb <= 1'b0; dev_write <= 1'b0; dev_size <= 1'b0; dev_offset <= '0; dev_wdata <= '0;
      rd_q <= 1'b0; hit_q <= 1'b0; ctl_q <= 1'b0; swap_q <= 1'b0; slot_q <= '0;
    end else begin
      io_stb   <= (req_win == W_REG && !space[1]) ? onehot : '0;
      id_stb   <= (req_win == W_REG && space == 2'd2) ? onehot : '0;
      int_stb  <= (req_win == W_REG && space == 2'd3) ? onehot : '0;
      mem_stb  <= (req_win == W_HMEM) ? onehot : '0;
      bmem_stb <= (req_win == W_BMEM) ? onehot : '0;
      ctl_stb  <= hit && req_win == W_CTL;
      rd_q     <= req_valid && !req_write;
      if (req_valid) begin
        dev_write  <= req_write;
        dev_size   <= req_size;
        dev_offset <= off;
        dev_wdata  <= swap ? {req_wdata[7:0], req_wdata[15:8]} : req_wdata;
        hit_q      <= hit;
        ctl_q      <= req_win == W_CTL;
        swap_q     <= swap;
        slot_q     <= slot_full[SW-1:0];
      end
    end
  end

  logic [15:0] raw;
  assign raw       = !hit_q ? 16'h0 : ctl_q ? ctl_rdata : slot_rdata[16*slot_q +: 16];
  assign rsp_valid = rd_q;
  assign rsp_rdata = !rd_q ? 16'h0 : swap_q ? {raw[7:0], raw[15:8]} : raw;

  logic any_stb;
  assign any_stb = |{io_stb, id_stb, int_stb, mem_stb, bmem_stb, ctl_stb};

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_stb, id_stb, int_stb, mem_stb, bmem_stb, ctl_stb}));
  a_r1_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(req_valid));
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r9_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r8_drop_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !any_stb) |-> rsp_rdata == 16'h0);
  a_r7_byte_window_half: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win == W_BMEM && req_size) |=> bmem_stb == '0);
  a_r7_ctl_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win == W_CTL && !req_size) |=> !ctl_stb);
endmodule

// File: tb/slot_decoder_test.sv
module slot_decoder_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_size = 0;
  logic [1:0] req_win = 0;
  logic [24:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [3:0] slot_present = 4'hF;
  logic [63:0] slot_rdata = {16'hD3C3, 16'hD2C2, 16'hD1C1, 16'hD0C0};
  logic [15:0] ctl_rdata = 16'h5A01;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [3:0] io_stb, id_stb, int_stb, mem_stb, bmem_stb;
  logic ctl_stb, dev_write, dev_size, rsp_valid;
  logic [22:0] dev_offset;
  logic [15:0] dev_wdata, rsp_rdata;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  slot_decoder uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] stbs();
    return {ctl_stb, bmem_stb, mem_stb, int_stb, id_stb, io_stb};
  endfunction

  task automatic req(logic [1:0] win, logic wr, logic sz, logic [24:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_win = win; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd(string tag, logic [7:0] a, logic [7:0] exp);
    cfg_addr = a; #1;
    chk(tag, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R11 strobes at reset", 32'(stbs()), 0);
    chk("R11 rsp_valid at reset", 32'(rsp_valid), 0);
    cfg_rd("R4 cfg 2B reset", 8'h2B, 0);
    cfg_rd("R4 cfg 2F reset", 8'h2F, 0);
    cfg_rd("R4 cfg 33 reset", 8'h33, 0);
  endtask

  task automatic t_reg_spaces();
    req(1, 1, 1, 25'h125, 16'h1234);
    chk("R1 io strobe slot1", 32'(io_stb), 4'b0010);
    chk("R1 io offset", 32'(dev_offset), 32'h25);
    chk("R1 io wdata", 32'(dev_wdata), 32'h1234);
    chk("R9 write no rsp", 32'(rsp_valid), 0);
    @(negedge clk);
    chk("R1 strobe one cycle", 32'(stbs()), 0);
    req(1, 1, 0, 25'h17F, 16'h0);
    chk("R1 space1 io", 32'(io_stb), 4'b0010);
    chk("R1 space1 offset", 32'(dev_offset), 32'h7F);
    req(1, 0, 0, 25'h2AB, 16'h0);
    chk("R1 id strobe slot2", 32'(stbs()), 32'(4'b0100) << 4);
    chk("R1 id offset", 32'(dev_offset), 32'h2B);
    chk("R9 id rsp_valid", 32'(rsp_valid), 1);
    chk("R9 id rdata", 32'(rsp_rdata), 32'hD2C2);
    req(1, 0, 1, 25'h3C5, 16'h0);
    chk("R1 int strobe slot3", 32'(int_stb), 4'b1000);
    chk("R1 int offset", 32'(dev_offset), 32'h05);
    chk("R9 int rdata", 32'(rsp_rdata), 32'hD3C3);
    @(negedge clk);
    chk("R9 rsp one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic t_mem();
    req(2, 0, 1, 25'h1812345, 16'h0);
    chk("R2 mem strobe slot3", 32'(mem_stb), 4'b1000);
    chk("R2 mem offset", 32'(dev_offset), 32'h12345);
    chk("R2 mem rdata", 32'(rsp_rdata), 32'hD3C3);
    req(3, 1, 0, 25'h083ABCD, 16'h0);
    chk("R3 bmem strobe slot2", 32'(bmem_stb), 4'b0100);
    chk("R3 bmem offset", 32'(dev_offset), 32'h3ABCD);
    req(3, 0, 1, 25'h0000010, 16'h0);
    chk("R7 bmem half no strobe", 32'(stbs()), 0);
    chk("R7 bmem half rsp_valid", 32'(rsp_valid), 1);
    chk("R7 bmem half rdata", 32'(rsp_rdata), 0);
  endtask

  task automatic t_cfg();
    cfg_wr(8'h2F, 8'hFF);
    cfg_rd("R4 cfg 2F set", 8'h2F, 8'h01);
    cfg_wr(8'h30, 8'hFF);
    cfg_rd("R4 cfg 30 ignored", 8'h30, 0);
    cfg_rd("R4 cfg 2B untouched", 8'h2B, 0);
    cfg_rd("R4 cfg 33 untouched", 8'h33, 0);
  endtask

  task automatic t_endian();
    req(1, 1, 0, 25'h124, 16'h0);
    chk("R5 byte addr invert", 32'(dev_offset), 32'h25);
    chk("R5 byte slot", 32'(io_stb), 4'b0010);
    req(1, 1, 1, 25'h124, 16'h1234);
    chk("R6 half offset kept", 32'(dev_offset), 32'h24);
    chk("R6 write swap", 32'(dev_wdata), 32'h3412);
    req(1, 0, 1, 25'h124, 16'h0);
    chk("R6 read swap", 32'(rsp_rdata), 32'hC1D1);
    req(1, 0, 0, 25'h124, 16'h0);
    chk("R6 byte read no swap", 32'(rsp_rdata), 32'hD1C1);
    req(2, 0, 0, 25'h0000001, 16'h0);
    chk("R5 win2 off when bit clear", 32'(dev_offset), 32'h1);
    cfg_wr(8'h33, 8'h01);
    req(2, 0, 0, 25'h0000001, 16'h0);
    chk("R5 win2 byte invert", 32'(dev_offset), 32'h0);
    chk("R5 win2 strobe", 32'(mem_stb), 4'b0001);
    req(3, 1, 0, 25'h0000005, 16'h0);
    chk("R3 bmem no adaptation", 32'(dev_offset), 32'h5);
    cfg_wr(8'h2F, 8'h00);
    cfg_wr(8'h33, 8'h00);
  endtask

  task automatic t_ctrl();
    req(0, 1, 1, 25'h0C, 16'hBEEF);
    chk("R10 ctl strobe", 32'(stbs()), 32'h100000);
    chk("R10 ctl offset", 32'(dev_offset), 32'h0C);
    chk("R10 ctl wdata", 32'(dev_wdata), 32'hBEEF);
    req(0, 0, 1, 25'h0C, 16'h0);
    chk("R10 ctl rdata", 32'(rsp_rdata), 32'h5A01);
    req(0, 0, 0, 25'h0C, 16'h0);
    chk("R7 ctl byte no strobe", 32'(stbs()), 0);
    chk("R7 ctl byte rdata", 32'(rsp_rdata), 0);
    cfg_wr(8'h2B, 8'h01);
    req(0, 1, 1, 25'h0C, 16'hBEEF);
    chk("R6 ctl write swap", 32'(dev_wdata), 32'hEFBE);
    req(0, 0, 1, 25'h0C, 16'h0);
    chk("R6 ctl read swap", 32'(rsp_rdata), 32'h015A);
    cfg_wr(8'h2B, 8'h00);
  endtask

  task automatic t_empty();
    slot_present = 4'b1011;
    req(1, 0, 1, 25'h225, 16'h0);
    chk("R8 absent no strobe", 32'(stbs()), 0);
    chk("R8 absent rsp_valid", 32'(rsp_valid), 1);
    chk("R8 absent rdata", 32'(rsp_rdata), 0);
    slot_present = 4'hF;
    req(1, 0, 1, 25'h225, 16'h0);
    chk("R8 present again", 32'(rsp_rdata), 32'hD2C2);
    req(1, 0, 1, 25'h400, 16'h0);
    chk("R8 reg slot4 no strobe", 32'(stbs()), 0);
    chk("R8 reg slot4 rdata", 32'(rsp_rdata), 0);
    req(3, 0, 0, 25'h1000000, 16'h0);
    chk("R8 bmem slot4 no strobe", 32'(stbs()), 0);
    chk("R8 bmem slot4 rdata", 32'(rsp_rdata), 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reg_spaces();
    t_mem();
    t_cfg();
    t_endian();
    t_ctrl();
    t_empty();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule